// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is a synchronous master for a three-wire serial EEPROM. It drives chip select, serial clock and serial data towards the memory, and it reads a serial data line back from the memory. The host logic issues one command at a time on a parallel request port. The command is one of seven: read, write, erase, erase-all, write-all, write-enable or write-disable. The request also carries an address and, where the command needs it, a write word.

The controller builds the bit frame for the command and shifts it out most significant bit first on a serial clock. That clock comes from the system clock through a divider. On a read, it collects the word that the memory returns. After a command that programs the array, it drops chip select for one full serial-clock period and then raises it again. It then polls the ready/busy level on the return line until the memory reports ready or a poll limit runs out.

A parameter selects the word organization. In 16-bit mode the address is 8 bits and the data is 16 bits. In 8-bit mode the address is 9 bits and the data is 8 bits.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is held and after it is released, chip select, serial clock, serial data out, `busy` and `done` are 0, and `req_ready` is 1.
- R2: A frame starts with a 1 bit and continues with a two-bit operation code: read 10, write 01, erase 11, and 00 for the four bulk/enable commands. The address follows, and then (for write and write-all only) the data word. All fields are sent most significant bit first.
- R3: The four 00-coded commands put a two-bit sub-code in the top two address bits: write-enable 11, write-disable 00, erase-all 10, write-all 01. The lower address bits are sent as 0.
- R4: One frame produces exactly 3+AW rising serial-clock edges for erase, erase-all, write-enable and write-disable. It produces 3+AW+DW edges for read, write and write-all: 11 and 27 in 16-bit mode, 12 and 20 in 8-bit mode. The serial clock only toggles while chip select is high.
- R5: Serial data out changes only while the serial clock is low. The memory samples it on the rising edge.
- R6: On a read, the controller samples the return line on the DW rising edges that follow the last address bit, most significant bit first. It presents the word on `rd_data` when `done` pulses.
- R7: After write, erase, erase-all and write-all, chip select goes low for at least 2*CLK_DIV system cycles and then high again. The controller then polls the return line and finishes when it reads 1.
- R8: If TIMEOUT polls read 0, the controller ends the command with `timeout_err` = 1 in the cycle of `done`. The flag clears when the next request is accepted.
- R9: Read, write-enable and write-disable raise chip select exactly once and run no polling phase.
- R10: `done` is high for exactly one cycle and `busy` is low in that cycle. `busy` is high from acceptance until `done`. A request presented while busy is ignored.
- R11: Command codes on `req_cmd` are: read 0, write 1, erase 2, erase-all 3, write-all 4, write-enable 5, write-disable 6. Code 7 is ignored and starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_cmd | input | 3 | Command code (see R11) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Word to write (write, write-all) |
| req_ready | output | 1 | Controller idle and able to take a request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Word returned by the last read |
| timeout_err | output | 1 | Status polling ran out |
| eep_cs | output | 1 | Chip select to the memory |
| eep_sk | output | 1 | Serial clock to the memory |
| eep_di | output | 1 | Serial data towards the memory |
| eep_do | input | 1 | Serial data / ready level from the memory |

## Verification
A request is taken on the rising edge at which it is seen. `busy` is therefore already high at the next falling system-clock edge. Each serial-clock half period lasts CLK_DIV system cycles. `done` rises one system cycle after the last falling serial-clock tick, or after the poll tick that reads ready or exhausts the limit. For that reason, each scenario waits on `done` at falling system-clock edges rather than counting a fixed number of cycles. Once `done` is seen, the scenario compares the bits, edge count and chip-select count captured by the memory model with values computed from the requirements. It then checks one falling edge later that `done` has dropped. The chip-select gap is measured in system cycles between the two chip-select edges.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_ERASE = 3'd2,
        CMD_ERAL  = 3'd3,
        CMD_WRAL  = 3'd4,
        CMD_WREN  = 3'd5,
        CMD_WRDIS = 3'd6
    } mw_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2,
        ST_POLL  = 2'd3
    } mw_state_e;

endpackage

// File: rtl/mw_sk_tick.sv
// Divider: one tick every DIV system cycles while run is high.
module mw_sk_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mw_frame.sv
// Builds the left-aligned serial frame and its length for one command.
module mw_frame
    import mw_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    localparam int HDR = 3 + AW,
    localparam int FW  = HDR + DW,
    localparam int LW  = $clog2(FW + 1)
) (
    input  logic [2:0]    cmd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [FW-1:0] frame,
    output logic [LW-1:0] nbits,
    output logic          is_read,
    output logic          is_prog,
    output logic          legal
);
    logic [1:0]    op;
    logic [AW-1:0] afield;
    logic [DW-1:0] dfield;
    logic          long_f;

    always_comb begin
        legal   = 1'b1;
        is_read = 1'b0;
        is_prog = 1'b0;
        long_f  = 1'b0;
        op      = 2'b00;
        afield  = addr;
        dfield  = '0;
        case (cmd)
            CMD_READ:  begin op = 2'b10; is_read = 1'b1; long_f = 1'b1; end
            CMD_WRITE: begin op = 2'b01; dfield = wdata; long_f = 1'b1; is_prog = 1'b1; end
            CMD_ERASE: begin op = 2'b11; is_prog = 1'b1; end
            CMD_ERAL:  begin afield = {2'b10, {(AW-2){1'b0}}}; is_prog = 1'b1; end
            CMD_WRAL:  begin
                afield = {2'b01, {(AW-2){1'b0}}};
                dfield = wdata; long_f = 1'b1; is_prog = 1'b1;
            end
            CMD_WREN:  afield = {2'b11, {(AW-2){1'b0}}};
            CMD_WRDIS: afield = {2'b00, {(AW-2){1'b0}}};
            default:   legal = 1'b0;
        endcase
        frame = {1'b1, op, afield, dfield};
        nbits = long_f ? LW'(FW) : LW'(HDR);
    end
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host
    import mw_pkg::*;
#(
    parameter bit WORD16  = 1'b1,
    parameter int CLK_DIV = 4,
    parameter int TIMEOUT = 256,
    localparam int AW  = WORD16 ? 8 : 9,
    localparam int DW  = WORD16 ? 16 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          timeout_err,
    output logic          eep_cs,
    output logic          eep_sk,
    output logic          eep_di,
    input  logic          eep_do
);
    localparam int HDR = 3 + AW;
    localparam int FW  = HDR + DW;
    localparam int LW  = $clog2(FW + 1);
    localparam int PW  = $clog2(TIMEOUT + 1);

    typedef struct packed {
        mw_state_e     st;
        logic [FW-1:0] sh;
        logic [LW-1:0] nbits;
        logic [LW-1:0] cnt;
        logic [DW-1:0] rsh;
        logic [DW-1:0] rdat;
        logic [PW-1:0] poll;
        logic          gap;
        logic          rd;
        logic          prog;
        logic          cs;
        logic          sk;
        logic          di;
        logic          done;
        logic          err;
    } regs_t;

    regs_t q, d;

    logic [FW-1:0] f_frame;
    logic [LW-1:0] f_nbits;
    logic          f_read, f_prog, f_legal;
    logic          tick;

    mw_frame #(.AW(AW), .DW(DW)) u_frame (
        .cmd     (req_cmd),
        .addr    (req_addr),
        .wdata   (req_wdata),
        .frame   (f_frame),
        .nbits   (f_nbits),
        .is_read (f_read),
        .is_prog (f_prog),
        .legal   (f_legal)
    );

    mw_sk_tick #(.DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .tick  (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid && f_legal) begin
                    d.st    = ST_SHIFT;
                    d.sh    = f_frame;
                    d.nbits = f_nbits;
                    d.cnt   = '0;
                    d.rd    = f_read;
                    d.prog  = f_prog;
                    d.cs    = 1'b1;
                    d.sk    = 1'b0;
                    d.di    = f_frame[FW-1];
                    d.err   = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sk) begin
                        // rising edge: count bit, capture read data past the header
                        d.sk  = 1'b1;
                        d.cnt = q.cnt + 1'b1;
                        if (q.rd && (q.cnt >= LW'(HDR)))
                            d.rsh = {q.rsh[DW-2:0], eep_do};
                    end else begin
                        // falling edge: advance data or end the frame
                        d.sk = 1'b0;
                        if (q.cnt == q.nbits) begin
                            d.cs = 1'b0;
                            d.di = 1'b0;
                            if (q.prog) begin
                                d.st  = ST_GAP;
                                d.gap = 1'b0;
                            end else begin
                                d.st   = ST_IDLE;
                                d.done = 1'b1;
                                if (q.rd) d.rdat = q.rsh;
                            end
                        end else begin
                            d.sh = q.sh << 1;
                            d.di = q.sh[FW-2];
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap) begin
                        d.cs   = 1'b1;
                        d.st   = ST_POLL;
                        d.poll = '0;
                    end else begin
                        d.gap = 1'b1;
                    end
                end
            end
            ST_POLL: begin
                if (tick) begin
                    if (eep_do) begin
                        d.cs   = 1'b0;
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else if (q.poll == PW'(TIMEOUT - 1)) begin
                        d.cs   = 1'b0;
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.poll = q.poll + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.st == ST_IDLE);
    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign rd_data     = q.rdat;
    assign timeout_err = q.err;
    assign eep_cs      = q.cs;
    assign eep_sk      = q.sk;
    assign eep_di      = q.di;
endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic eep_cs,
    input logic eep_sk,
    input logic eep_di
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!eep_cs && !eep_sk && !eep_di));

    assert_sk_under_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eep_sk |-> eep_cs);

    assert_di_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eep_sk && $past(eep_sk)) |-> $stable(eep_di));

    assert_err_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && req_ready));
endmodule

bind mw_eeprom_host mw_eeprom_host_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .eep_cs      (eep_cs),
    .eep_sk      (eep_sk),
    .eep_di      (eep_di)
);

// File: tb/mw_eeprom_host_bench.sv
module mw_eeprom_host_bench;
    localparam bit WORD16  = 1'b1;
    localparam int CLK_DIV = 2;
    localparam int TIMEOUT = 20;
    localparam int AW  = WORD16 ? 8 : 9;
    localparam int DW  = WORD16 ? 16 : 8;
    localparam int HDR = 3 + AW;
    localparam int FW  = HDR + DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [2:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, busy, done, timeout_err;
    logic [DW-1:0] rd_data;
    logic          eep_cs, eep_sk, eep_di, eep_do;

    mw_eeprom_host #(.WORD16(WORD16), .CLK_DIV(CLK_DIV), .TIMEOUT(TIMEOUT)) u_mw_eeprom_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .busy(busy), .done(done), .rd_data(rd_data), .timeout_err(timeout_err),
        .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_di(eep_di), .eep_do(eep_do)
    );

    int checks = 0;
    int errors = 0;

    // memory model
    logic [63:0]   cap;
    int            nrise, ncs;
    logic          rd_mode = 1'b0, do_rd = 1'b0, ready_flag = 1'b0;
    logic [DW-1:0] rd_word = '0;
    longint        cyc = 0, t_fall = 0, last_gap = 0;

    assign eep_do = rd_mode ? do_rd : ready_flag;

    always @(negedge clk) cyc = cyc + 1;
    always @(posedge eep_sk) if (eep_cs) begin cap = {cap[62:0], eep_di}; nrise = nrise + 1; end
    always @(negedge eep_sk)
        if (eep_cs && nrise >= HDR && nrise < FW) do_rd = rd_word[DW-1-(nrise-HDR)];
    always @(posedge eep_cs) begin ncs = ncs + 1; last_gap = cyc - t_fall; end
    always @(negedge eep_cs) t_fall = cyc;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic build(input [2:0] cmd, input [AW-1:0] a, input [DW-1:0] w,
                         output logic [63:0] f, output int len, output bit prog);
        logic [1:0]    op;
        logic [AW-1:0] af;
        bit            lng;
        af = a; lng = 0; prog = 0; op = 2'b00;
        case (cmd)
            3'd0: begin op = 2'b10; lng = 1; end
            3'd1: begin op = 2'b01; lng = 1; prog = 1; end
            3'd2: begin op = 2'b11; prog = 1; end
            3'd3: begin af = '0; af[AW-1:AW-2] = 2'b10; prog = 1; end
            3'd4: begin af = '0; af[AW-1:AW-2] = 2'b01; lng = 1; prog = 1; end
            3'd5: begin af = '0; af[AW-1:AW-2] = 2'b11; end
            default: begin af = '0; end
        endcase
        f = 64'd1;
        f = (f << 2) | 64'(op);
        f = (f << AW) | 64'(af);
        len = HDR;
        if (lng) begin
            f = (f << DW) | ((cmd == 3'd0) ? 64'd0 : 64'(w));
            len = FW;
        end
    endtask

    task automatic issue(input [2:0] cmd, input [AW-1:0] a, input [DW-1:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // one full command with all result checks
    task automatic run_cmd(input [2:0] cmd, input [AW-1:0] a, input [DW-1:0] w,
                           input int delay, input bit exp_err, input string req);
        logic [63:0] f;
        int          len;
        bit          prog;
        build(cmd, a, w, f, len, prog);
        cap = '0; nrise = 0; ncs = 0; last_gap = 0;
        rd_mode = (cmd == 3'd0); ready_flag = 1'b0;
        if (delay >= 0)
            fork
                begin
                    @(negedge eep_cs);
                    repeat (delay) @(negedge clk);
                    ready_flag = 1'b1;
                end
            join_none
        issue(cmd, a, w);
        check(busy == 1'b1 && req_ready == 1'b0, "R10", "busy after accept", busy, 1);
        wait_done();
        check(nrise == len, "R4", "rising edges", nrise, len);
        check((cap & ((64'd1 << len) - 1)) == f, req, "frame bits", cap, f);
        check(ncs == (prog ? 2 : 1), prog ? "R7" : "R9", "cs assertions", ncs, prog ? 2 : 1);
        check(timeout_err == exp_err, "R8", "timeout flag", timeout_err, exp_err);
        check(busy == 1'b0, "R10", "busy at done", busy, 0);
        if (prog) check(last_gap >= 2 * CLK_DIV, "R7", "cs gap cycles", last_gap, 2 * CLK_DIV);
        if (cmd == 3'd0) check(rd_data == rd_word, "R6", "read word", rd_data, rd_word);
        @(negedge clk);
        check(done == 1'b0, "R10", "done width", done, 0);
        rd_mode = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!eep_cs && !eep_sk && !eep_di && !busy && !done && req_ready, "R1",
              "outputs in reset", {eep_cs, eep_sk, eep_di, busy, done, req_ready}, 6'b000001);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!eep_cs && !eep_sk && !busy && req_ready, "R1", "outputs after reset",
              {eep_cs, eep_sk, busy, req_ready}, 4'b0001);
    endtask

    task automatic t_illegal();
        ncs = 0;
        issue(3'd7, '1, '1);
        repeat (12) @(negedge clk);
        check(ncs == 0 && !busy && !eep_cs, "R11", "code 7 ignored", ncs, 0);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] f;
        int          len;
        bit          prog;
        build(3'd0, 8'h21, '0, f, len, prog);
        cap = '0; nrise = 0; ncs = 0; rd_mode = 1'b1; rd_word = 16'h5AC3;
        issue(3'd0, 8'h21, '0);
        repeat (6) @(negedge clk);
        issue(3'd2, 8'h44, '0);
        wait_done();
        check(rd_data == rd_word, "R6", "read under extra request", rd_data, rd_word);
        repeat (20) @(negedge clk);
        check(ncs == 1 && nrise == len && !busy, "R10", "request while busy dropped", ncs, 1);
        rd_mode = 1'b0;
    endtask

    initial begin
        fork
            begin
                t_reset();
                run_cmd(3'd5, 8'h00, '0, 0, 1'b0, "R3");          // write-enable
                run_cmd(3'd1, 8'hA5, 16'h1234, 10, 1'b0, "R2");   // write
                rd_word = 16'hBEEF;
                run_cmd(3'd0, 8'h3C, '0, 0, 1'b0, "R6");          // read
                run_cmd(3'd2, 8'h7F, '0, 0, 1'b0, "R2");          // erase
                run_cmd(3'd3, 8'hFF, '0, 3, 1'b0, "R3");          // erase-all
                run_cmd(3'd4, 8'h55, 16'hC0DE, 5, 1'b0, "R3");    // write-all
                run_cmd(3'd6, 8'hFF, '0, 0, 1'b0, "R3");          // write-disable
                run_cmd(3'd1, 8'h01, 16'h8001, -1, 1'b1, "R8");   // never ready
                run_cmd(3'd2, 8'h02, '0, 0, 1'b0, "R8");          // flag clears
                check(timeout_err == 1'b0, "R8", "flag cleared", timeout_err, 0);
                rd_word = 16'h0F0F;
                run_cmd(3'd0, 8'hFF, '0, 0, 1'b0, "R5");
                t_illegal();
                t_busy_ignore();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule